// File: doc/BRIEF.md
# Transmit Frame Header Checker

This block sits in the transmit path of a time-triggered bus communication controller. When a message buffer's frame header is latched for transmission, the block compares two header fields against the controller configuration. The first is the frame ID, compared with the buffer's configured ID. The second is the payload length, compared with the configured static payload length, and only for static-segment buffers. On a mismatch it raises a sticky error flag. It then emits the header words that actually go on the bus. A mismatching field is replaced by the configured value, so the frame sent is always well formed.

Buffers assigned to the key slot skip every check, and their header passes through untouched. The block also holds a combinational gate that decides whether a host write to a header field is allowed. The gate depends on the buffer kind, the controller state and the buffer's disable bit.

Top module: `tx_hdr_checker`

## Requirements
- R1: Header word 0 carries the frame ID in bits [10:0], and word 1 carries the payload length in bits [6:0]. A pulse on `hdr_load_i` produces `tx_valid_o` high for one cycle on the next clock. In that cycle word 2 appears on `tx_w2_o` unchanged.
- R2: With `key_slot_i` high, words 0 and 1 are sent exactly as stored and neither error flag is set.
- R3: For a non-key-slot buffer, a stored frame ID that differs from `cfg_fid_i` sets `fid_err_o` on the clock that latches the header.
- R4: For a non-key-slot buffer, `tx_w0_o[10:0]` equals `cfg_fid_i`, and bits [15:11] are kept as stored.
- R5: For a non-key-slot static-segment buffer (`static_seg_i` high), a stored payload length that differs from `cfg_static_len_i` sets `len_err_o`.
- R6: For a non-key-slot static-segment buffer, `tx_w1_o[6:0]` equals `cfg_static_len_i`, and bits [15:7] are kept as stored.
- R7: For a dynamic-segment buffer (`static_seg_i` low), word 1 is sent unchanged and `len_err_o` is not set.
- R8: Both flags are sticky. `flag_clr_i[0]` clears `fid_err_o` and `flag_clr_i[1]` clears `len_err_o`, one for one. When a set and a clear for the same flag fall in the same cycle, the set wins.
- R9: `irq_o` is high exactly when at least one error flag is set.
- R10: Host header writes to receive buffers are refused. The buffer kind is coded 0 = transmit, 1 = receive, 2 = receive shadow, 3 = receive FIFO, and `wr_grant_o` is low for kinds 1 to 3.
- R11: For a transmit buffer, `wr_grant_o` equals `wr_req_i` AND (`cfg_state_i` OR `buf_dis_i`).
- R12: After reset, `tx_valid_o`, both flags, `irq_o` and the three transmit words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_load_i | input | 1 | Header words are latched for transmission this cycle |
| hdr_w0_i | input | 16 | Stored header word 0 (indicator bits, frame ID) |
| hdr_w1_i | input | 16 | Stored header word 1 (cycle count, payload length) |
| hdr_w2_i | input | 16 | Stored header word 2 (header CRC) |
| cfg_fid_i | input | 11 | Configured frame ID of the buffer |
| key_slot_i | input | 1 | Buffer is assigned to the key slot |
| static_seg_i | input | 1 | Buffer belongs to the static segment |
| cfg_static_len_i | input | 7 | Configured static payload length |
| flag_clr_i | input | 2 | Write-one-to-clear strobes: bit 0 frame ID flag, bit 1 length flag |
| wr_req_i | input | 1 | Host requests a header field write |
| wr_buf_kind_i | input | 2 | Kind of the addressed buffer |
| cfg_state_i | input | 1 | Controller is in configuration state |
| buf_dis_i | input | 1 | Addressed buffer is disabled |
| wr_grant_o | output | 1 | Host header write permitted |
| tx_valid_o | output | 1 | Corrected header words valid |
| tx_w0_o | output | 16 | Transmitted header word 0 |
| tx_w1_o | output | 16 | Transmitted header word 1 |
| tx_w2_o | output | 16 | Transmitted header word 2 |
| fid_err_o | output | 1 | Sticky frame ID error flag |
| len_err_o | output | 1 | Sticky static payload length error flag |
| irq_o | output | 1 | Combined error interrupt |

## Verification
The checker assumes that the header inputs, the configured values and the segment and key-slot indicators are stable and meaningful in the cycle `hdr_load_i` is high. It compares the next-cycle outputs with the values sampled on that edge. The stickiness property assumes that only `flag_clr_i` can lower a flag. The bench drives every input on the falling clock edge and holds the header inputs together with the load pulse. It raises clear strobes only where a test targets the clear path, including one cycle in which a clear and a new mismatch coincide.

// File: rtl/tx_hdr_pkg.sv
package tx_hdr_pkg;
  localparam int unsigned HDR_WORD_W = 16;
  localparam int unsigned HDR_FID_W  = 11;
  localparam int unsigned HDR_LEN_W  = 7;
  localparam int unsigned HDR_FID_LSB = 0;
  localparam int unsigned HDR_LEN_LSB = 0;
  localparam int unsigned HDR_NFLAGS = 2;

  typedef enum logic [1:0] {
    BUF_TX        = 2'd0,
    BUF_RX        = 2'd1,
    BUF_RX_SHADOW = 2'd2,
    BUF_RX_FIFO   = 2'd3
  } buf_kind_e;

  typedef enum int unsigned {
    FLG_FID = 0,
    FLG_LEN = 1
  } flag_idx_e;
endpackage

// File: rtl/hdr_field_check.sv
module hdr_field_check #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned FLD_W  = 11,
  parameter int unsigned FLD_LSB = 0
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [FLD_W-1:0]  cfg_i,
  input  logic              en_i,
  output logic              mismatch_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WORD_W-1:0] FLD_MASK = WORD_W'(((64'd1 << FLD_W) - 64'd1) << FLD_LSB);

  logic [FLD_W-1:0] fld;

  assign fld        = FLD_W'(word_i >> FLD_LSB);
  assign mismatch_o = en_i && (fld != cfg_i);
  // configured value always wins when the check is enabled
  assign word_o     = en_i ? ((word_i & ~FLD_MASK) | (WORD_W'(cfg_i) << FLD_LSB)) : word_i;
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[g] <= 1'b0;
      else if (set_i[g])  flag_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])  flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/hdr_wr_gate.sv
module hdr_wr_gate
  import tx_hdr_pkg::*;
(
  input  logic      wr_req_i,
  input  buf_kind_e kind_i,
  input  logic      cfg_state_i,
  input  logic      buf_dis_i,
  output logic      grant_o
);
  always_comb begin
    unique case (kind_i)
      BUF_TX:  grant_o = wr_req_i && (cfg_state_i || buf_dis_i);
      default: grant_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tx_hdr_checker.sv
module tx_hdr_checker
  import tx_hdr_pkg::*;
#(
  parameter int unsigned WORD_W = HDR_WORD_W,
  parameter int unsigned FID_W  = HDR_FID_W,
  parameter int unsigned LEN_W  = HDR_LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_load_i,
  input  logic [WORD_W-1:0] hdr_w0_i,
  input  logic [WORD_W-1:0] hdr_w1_i,
  input  logic [WORD_W-1:0] hdr_w2_i,
  input  logic [FID_W-1:0]  cfg_fid_i,
  input  logic              key_slot_i,
  input  logic              static_seg_i,
  input  logic [LEN_W-1:0]  cfg_static_len_i,
  input  logic [1:0]        flag_clr_i,
  input  logic              wr_req_i,
  input  logic [1:0]        wr_buf_kind_i,
  input  logic              cfg_state_i,
  input  logic              buf_dis_i,
  output logic              wr_grant_o,
  output logic              tx_valid_o,
  output logic [WORD_W-1:0] tx_w0_o,
  output logic [WORD_W-1:0] tx_w1_o,
  output logic [WORD_W-1:0] tx_w2_o,
  output logic              fid_err_o,
  output logic              len_err_o,
  output logic              irq_o
);
  localparam int unsigned NFLAGS = HDR_NFLAGS;

  logic              fid_chk_en, len_chk_en;
  logic              fid_mis, len_mis;
  logic [WORD_W-1:0] w0_fix, w1_fix;
  logic [NFLAGS-1:0] flag_set, flags;

  assign fid_chk_en = !key_slot_i;
  assign len_chk_en = !key_slot_i && static_seg_i;

  hdr_field_check #(.WORD_W(WORD_W), .FLD_W(FID_W), .FLD_LSB(HDR_FID_LSB)) u_fid_chk (
    .word_i(hdr_w0_i), .cfg_i(cfg_fid_i), .en_i(fid_chk_en),
    .mismatch_o(fid_mis), .word_o(w0_fix)
  );

  hdr_field_check #(.WORD_W(WORD_W), .FLD_W(LEN_W), .FLD_LSB(HDR_LEN_LSB)) u_len_chk (
    .word_i(hdr_w1_i), .cfg_i(cfg_static_len_i), .en_i(len_chk_en),
    .mismatch_o(len_mis), .word_o(w1_fix)
  );

  assign flag_set[FLG_FID] = hdr_load_i && fid_mis;
  assign flag_set[FLG_LEN] = hdr_load_i && len_mis;

  sticky_flags #(.N(NFLAGS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flag_set), .clr_i(flag_clr_i), .flag_o(flags)
  );

  hdr_wr_gate u_wr_gate (
    .wr_req_i(wr_req_i), .kind_i(buf_kind_e'(wr_buf_kind_i)),
    .cfg_state_i(cfg_state_i), .buf_dis_i(buf_dis_i), .grant_o(wr_grant_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_w0_o    <= '0;
      tx_w1_o    <= '0;
      tx_w2_o    <= '0;
    end else begin
      tx_valid_o <= hdr_load_i;
      if (hdr_load_i) begin
        tx_w0_o <= w0_fix;
        tx_w1_o <= w1_fix;
        tx_w2_o <= hdr_w2_i;
      end
    end
  end

  assign fid_err_o = flags[FLG_FID];
  assign len_err_o = flags[FLG_LEN];
  assign irq_o     = |flags;
endmodule

// File: rtl/tx_hdr_checker_sva.sv
module tx_hdr_checker_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hdr_load_i,
  input logic [15:0] hdr_w0_i,
  input logic [15:0] hdr_w1_i,
  input logic [15:0] hdr_w2_i,
  input logic [10:0] cfg_fid_i,
  input logic        key_slot_i,
  input logic        static_seg_i,
  input logic [6:0]  cfg_static_len_i,
  input logic [1:0]  flag_clr_i,
  input logic        wr_req_i,
  input logic [1:0]  wr_buf_kind_i,
  input logic        cfg_state_i,
  input logic        buf_dis_i,
  input logic        wr_grant_o,
  input logic        tx_valid_o,
  input logic [15:0] tx_w0_o,
  input logic [15:0] tx_w1_o,
  input logic [15:0] tx_w2_o,
  input logic        fid_err_o,
  input logic        len_err_o,
  input logic        irq_o
);
  AST_LOAD_TO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_load_i |=> (tx_valid_o && tx_w2_o == $past(hdr_w2_i))); // R1

  AST_KEY_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_load_i && key_slot_i) |=>
      (tx_w0_o == $past(hdr_w0_i) && tx_w1_o == $past(hdr_w1_i))); // R2

  AST_FID_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_load_i && !key_slot_i && hdr_w0_i[10:0] != cfg_fid_i) |=> fid_err_o); // R3

  AST_FID_SUBST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_load_i && !key_slot_i) |=> (tx_w0_o[10:0] == $past(cfg_fid_i))); // R4

  AST_LEN_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_load_i && !key_slot_i && static_seg_i && hdr_w1_i[6:0] != cfg_static_len_i)
      |=> len_err_o); // R5

  AST_LEN_SUBST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_load_i && !key_slot_i && static_seg_i) |=> (tx_w1_o[6:0] == $past(cfg_static_len_i))); // R6

  AST_DYN_LEN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_load_i && !static_seg_i) |=> (tx_w1_o == $past(hdr_w1_i))); // R7

  AST_FID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fid_err_o && !flag_clr_i[0]) |=> fid_err_o); // R8

  AST_LEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_err_o && !flag_clr_i[1]) |=> len_err_o); // R8

  AST_RX_WRITE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_buf_kind_i != 2'd0) |-> !wr_grant_o); // R10

  AST_TX_WRITE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_grant_o) |-> (cfg_state_i || buf_dis_i)); // R11
endmodule

bind tx_hdr_checker tx_hdr_checker_sva u_sva (.*);

// File: tb/tx_hdr_checker_test.sv
module tx_hdr_checker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hdr_load_i = 1'b0;
  logic [15:0] hdr_w0_i = '0, hdr_w1_i = '0, hdr_w2_i = '0;
  logic [10:0] cfg_fid_i = '0;
  logic        key_slot_i = 1'b0, static_seg_i = 1'b0;
  logic [6:0]  cfg_static_len_i = '0;
  logic [1:0]  flag_clr_i = '0;
  logic        wr_req_i = 1'b0;
  logic [1:0]  wr_buf_kind_i = '0;
  logic        cfg_state_i = 1'b0, buf_dis_i = 1'b0;
  logic        wr_grant_o, tx_valid_o, fid_err_o, len_err_o, irq_o;
  logic [15:0] tx_w0_o, tx_w1_o, tx_w2_o;

  int checks = 0;
  int failures = 0;
  logic mdl_fid = 1'b0, mdl_len = 1'b0;

  typedef struct packed {
    logic [15:0] w0, w1, w2;
    logic        fid, len;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk_i = ~clk_i;

  tx_hdr_checker uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one header load, optional clear strobe in the same cycle
  task automatic send(logic [15:0] w0, logic [15:0] w1, logic [15:0] w2,
                      logic [10:0] fid, logic key, logic stat, logic [6:0] len,
                      logic [1:0] clr);
    exp_t e;
    logic fe, le;
    fe = !key && (w0[10:0] != fid);
    le = !key && stat && (w1[6:0] != len);
    mdl_fid = fe || (mdl_fid && !clr[0]);
    mdl_len = le || (mdl_len && !clr[1]);
    e.w0  = key ? w0 : {w0[15:11], fid};
    e.w1  = (!key && stat) ? {w1[15:7], len} : w1;
    e.w2  = w2;
    e.fid = mdl_fid;
    e.len = mdl_len;
    @(negedge clk_i);
    hdr_w0_i = w0; hdr_w1_i = w1; hdr_w2_i = w2;
    cfg_fid_i = fid; key_slot_i = key; static_seg_i = stat; cfg_static_len_i = len;
    flag_clr_i = clr; hdr_load_i = 1'b1;
    exp_q.push_back(e);
    @(negedge clk_i);
    hdr_load_i = 1'b0; flag_clr_i = '0;
  endtask

  task automatic clear(logic [1:0] clr);
    @(negedge clk_i);
    flag_clr_i = clr;
    if (clr[0]) mdl_fid = 1'b0;
    if (clr[1]) mdl_len = 1'b0;
    @(negedge clk_i);
    flag_clr_i = '0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && tx_valid_o) begin
      if (exp_q.size() == 0) begin
        chk("R1 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R4 R2 word0", tx_w0_o, e.w0);
        chk("R6 R7 word1", tx_w1_o, e.w1);
        chk("R1 word2", tx_w2_o, e.w2);
        chk("R3 fid flag", fid_err_o, e.fid);
        chk("R5 len flag", len_err_o, e.len);
        chk("R9 irq", irq_o, e.fid || e.len);
      end
    end
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R12 reset state
    chk("R12 valid", tx_valid_o, 0);
    chk("R12 flags", {fid_err_o, len_err_o, irq_o}, 0);
    chk("R12 words", {tx_w0_o, tx_w1_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // matching static header: no errors
    send(16'h6123, 16'h0A10, 16'h1F2E, 11'h123, 0, 1, 7'h10, 2'b00);
    // R3/R4 fid mismatch, static len ok
    send(16'h4055, 16'h0320, 16'hBEEF, 11'h077, 0, 1, 7'h20, 2'b00);
    clear(2'b11);
    // R5/R6 len mismatch, cycle count bits kept
    send(16'h2077, 16'h3F7F, 16'h0001, 11'h077, 0, 1, 7'h05, 2'b00);
    clear(2'b11);
    // R7 dynamic: len passes through, only fid check
    send(16'h1001, 16'h0512, 16'h00AA, 11'h002, 0, 0, 7'h40, 2'b00);
    clear(2'b11);
    // R2 key slot: both fields differ but pass unchanged, no flags
    send(16'h7FFF, 16'h2B7E, 16'h5555, 11'h000, 1, 1, 7'h01, 2'b00);
    // back-to-back loads
    send(16'h0010, 16'h0108, 16'h1234, 11'h010, 0, 1, 7'h08, 2'b00);
    send(16'h0011, 16'h0209, 16'h4321, 11'h010, 0, 0, 7'h08, 2'b00);
    // R8 set wins over same-cycle clear
    send(16'h0300, 16'h0003, 16'h0000, 11'h301, 0, 1, 7'h03, 2'b01);
    repeat (4) @(negedge clk_i);
    chk("R8 fid sticky", fid_err_o, 1);
    chk("R9 irq high", irq_o, 1);
    clear(2'b10);
    chk("R8 clear other bit keeps fid", fid_err_o, 1);
    clear(2'b01);
    chk("R8 fid cleared", fid_err_o, 0);
    chk("R9 irq low", irq_o, 0);
    send(16'h0000, 16'h0011, 16'h0000, 11'h000, 0, 1, 7'h12, 2'b00);
    clear(2'b01);
    chk("R8 clear fid keeps len", len_err_o, 1);
    clear(2'b10);
    chk("R8 len cleared", len_err_o, 0);

    // R10 / R11 write gate
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 4; s++) begin
        logic exp_g;
        @(negedge clk_i);
        wr_req_i = 1'b1; wr_buf_kind_i = 2'(k);
        cfg_state_i = s[0]; buf_dis_i = s[1];
        #1;
        exp_g = (k == 0) && (s != 0);
        if (k == 0) chk("R11 tx gate", wr_grant_o, exp_g);
        else        chk("R10 rx gate", wr_grant_o, exp_g);
      end
    end
    @(negedge clk_i);
    wr_req_i = 1'b0; wr_buf_kind_i = 2'd0; cfg_state_i = 1'b1;
    #1;
    chk("R11 no request", wr_grant_o, 0);

    repeat (3) @(negedge clk_i);
    chk("R1 all loads seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule